// File: doc/BRIEF.md
# Paged TCAM Entry Access Engine

The engine gives a host indirect access to the entries of a ternary match table through a small window of 16-bit registers. Each table entry is stored as three pages. Page 0 holds the key header and the first frame-match bytes, page 1 holds the remaining frame-match bytes, and page 2 holds the action words. The host never addresses the table directly. It stages a page image in a bank of 26 data registers at offsets 2 to 27. It then writes the operation register with the busy bit set, and polls until the engine clears that bit.

Five operations are provided:

- **Read page** copies a stored page into the data registers.
- **Load page** writes the data registers into a stored page.
- **Flush one** clears all three pages of a single entry.
- **Flush all** walks the whole table, one entry per cycle.
- **Get next** searches for the next valid entry above a given index.

An extension register at offset 1 selects the table block that the operations act on. The matching datapath that consumes the table lies outside this block.

Top module: `tcam_page_engine`

## Requirements

- R1: After reset, the following all read 0: the operation register (offset 0), the extension register (offset 1) and every data register (offsets 2–27). No entry is valid after reset, so a get-next from index 0 returns the all-ones index.
- R2: The operation register is laid out as follows: bit 15 busy, bits 14:12 opcode, bits 11:10 page, bits 9:0 entry index. A host write with bit 15 set, made while idle, starts the operation and busy then reads 1. Every opcode other than 1 completes on the next clock, so busy reads 1 for exactly one cycle. A write with bit 15 clear only stores the three fields and starts nothing.
- R3: Opcode 3 (load page) writes data registers 2–27 into the page selected by bits 11:10 of the entry selected by the index. Opcode 5 (read page) copies that page back into the data registers. The three pages of an entry are independent. Page value 3 makes both operations do nothing.
- R4: An entry is valid exactly when its page 0 was last loaded with a nonzero frame-type mask in bits 15:14 of offset 2. Loading pages 1 or 2 does not make an entry valid.
- R5: Opcode 2 (flush one) clears all three pages of the indexed entry and makes it invalid. Every other entry is left unchanged.
- R6: Opcode 1 (flush all) clears every entry of every block. Busy stays high for exactly BLOCKS×ENTRIES cycles.
- R7: Opcode 4 (get next) searches the selected block for valid entries whose index is greater than the index field. It writes the smallest such index into the index field, or 0x3FF if there is none. The opcode and page fields are kept.
- R8: The low bits of the extension register select the block. The same index in two blocks names two separate entries. The extension register reads back the block number.
- R9: While busy is high, every host write is ignored: to the operation register, to the extension register and to the data registers.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Register offset for reads and writes |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register contents at host_addr; purely combinational |

## Verification

A wrong internal state usually becomes visible on the first host access after the operation that caused it.

- A wrong valid bit shows in the index returned by the next get-next, one cycle after that get-next is issued.
- A wrongly written or wrongly cleared page shows when a later read page places it in the data registers, one cycle after issue.
- A miscounting flush walker shows as busy staying high for the wrong number of cycles, or as a stale entry that a later get-next still finds.
- A leak of host writes during busy shows as changed operation fields, a changed block number or changed data registers once busy falls.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    localparam int WORD_W      = 16;
    localparam int PAGE_WORDS  = 26;
    localparam int NUM_PAGES   = 3;
    localparam int IDX_FIELD_W = 10;

    localparam logic [2:0] OPC_FLUSH_ALL = 3'd1;
    localparam logic [2:0] OPC_FLUSH_ONE = 3'd2;
    localparam logic [2:0] OPC_LOAD      = 3'd3;
    localparam logic [2:0] OPC_NEXT      = 3'd4;
    localparam logic [2:0] OPC_READ      = 3'd5;

    typedef logic [PAGE_WORDS-1:0][WORD_W-1:0] page_t;

endpackage

// File: rtl/tcam_entry_store.sv
module tcam_entry_store
    import tcam_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_entry,
    input  logic [1:0]        rd_page,
    output page_t             rd_data,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_entry,
    input  logic [1:0]        wr_page,
    input  page_t             wr_data,
    input  logic              clr_en,
    input  logic [SLOT_W-1:0] clr_entry,
    output logic [SLOTS-1:0]  valid
);

    page_t            mem_q [SLOTS][NUM_PAGES];
    logic [SLOTS-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < SLOTS; e++) begin
                for (int p = 0; p < NUM_PAGES; p++) begin
                    mem_q[e][p] <= '0;
                end
            end
            valid_q <= '0;
        end else if (clr_en) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                mem_q[clr_entry][p] <= '0;
            end
            valid_q[clr_entry] <= 1'b0;
        end else if (wr_en && wr_page != 2'd3) begin
            mem_q[wr_entry][wr_page] <= wr_data;
            if (wr_page == 2'd0) begin
                valid_q[wr_entry] <= (wr_data[0][15:14] != 2'b00);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_page != 2'd3) begin
            rd_data = mem_q[rd_entry][rd_page];
        end
    end

    assign valid = valid_q;

    // R5: a flushed slot is invalid on the following cycle
    p_flush_clears_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !valid_q[$past(clr_entry)]);

endmodule

// File: rtl/tcam_next_finder.sv
module tcam_next_finder #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_blk,
    input  logic [IDX_W-1:0]   start,
    output logic               found,
    output logic [IDX_W-1:0]   hit
);

    always_comb begin
        found = 1'b0;
        hit   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (valid_blk[i] && i > int'(start)) begin
                found = 1'b1;
                hit   = IDX_W'(i);
            end
        end
        // R7: a reported hit is a valid slot above the start index
        p_hit_above_start_r7: assert (!found || (valid_blk[hit] && hit > start));
    end

endmodule

// File: rtl/tcam_op_ctrl.sv
module tcam_op_ctrl
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int BLOCKS  = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int SLOT_W = BLK_W + IDX_W,
    localparam int TOTAL  = BLOCKS * ENTRIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [4:0]        host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic [BLK_W-1:0]  blk_sel,
    output logic [IDX_W-1:0]  search_start,
    input  logic              search_found,
    input  logic [IDX_W-1:0]  search_hit,
    output logic [SLOT_W-1:0] rd_entry,
    output logic [1:0]        rd_page,
    input  page_t             rd_data,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_entry,
    output logic [1:0]        wr_page,
    output page_t             wr_data,
    output logic              clr_en,
    output logic [SLOT_W-1:0] clr_entry
);

    typedef struct packed {
        logic                   busy;
        logic [2:0]             opc;
        logic [1:0]             page;
        logic [IDX_FIELD_W-1:0] idx;
        logic [BLK_W-1:0]       ext;
        page_t                  data;
        logic [SLOT_W-1:0]      walk;
    } ctrl_t;

    ctrl_t             st_d, st_q;
    logic [SLOT_W-1:0] cur_slot;
    logic              data_ofs;

    assign cur_slot = {st_q.ext, st_q.idx[IDX_W-1:0]};
    assign data_ofs = (host_addr >= 5'd2) && (host_addr <= 5'd27);

    always_comb begin
        st_d         = st_q;
        rd_entry     = cur_slot;
        rd_page      = st_q.page;
        wr_en        = 1'b0;
        wr_entry     = cur_slot;
        wr_page      = st_q.page;
        wr_data      = st_q.data;
        clr_en       = 1'b0;
        clr_entry    = cur_slot;
        search_start = st_q.idx[IDX_W-1:0];

        if (st_q.busy) begin
            case (st_q.opc)
                OPC_FLUSH_ALL: begin
                    clr_en    = 1'b1;
                    clr_entry = st_q.walk;
                    if (st_q.walk == SLOT_W'(TOTAL - 1)) begin
                        st_d.busy = 1'b0;
                        st_d.walk = '0;
                    end else begin
                        st_d.walk = st_q.walk + 1'b1;
                    end
                end
                OPC_FLUSH_ONE: begin
                    clr_en    = 1'b1;
                    st_d.busy = 1'b0;
                end
                OPC_LOAD: begin
                    wr_en     = (st_q.page != 2'd3);
                    st_d.busy = 1'b0;
                end
                OPC_READ: begin
                    if (st_q.page != 2'd3) begin
                        st_d.data = rd_data;
                    end
                    st_d.busy = 1'b0;
                end
                OPC_NEXT: begin
                    st_d.idx  = search_found ? IDX_FIELD_W'(search_hit) : '1;
                    st_d.busy = 1'b0;
                end
                default: st_d.busy = 1'b0;
            endcase
        end else if (host_we) begin
            if (host_addr == 5'd0) begin
                st_d.busy = host_wdata[15];
                st_d.opc  = host_wdata[14:12];
                st_d.page = host_wdata[11:10];
                st_d.idx  = host_wdata[9:0];
                st_d.walk = '0;
            end else if (host_addr == 5'd1) begin
                st_d.ext = host_wdata[BLK_W-1:0];
            end else if (data_ofs) begin
                st_d.data[host_addr - 5'd2] = host_wdata;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == 5'd0) begin
            host_rdata = {st_q.busy, st_q.opc, st_q.page, st_q.idx};
        end else if (host_addr == 5'd1) begin
            host_rdata = 16'(st_q.ext);
        end else if (data_ofs) begin
            host_rdata = st_q.data[host_addr - 5'd2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blk_sel = st_q.ext;

    // R9: an operation-register write during busy leaves the fields alone
    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && host_we && host_addr == 5'd0) |=> ($stable(st_q.opc) && $stable(st_q.page)));

    // R2: single-entry operations finish on the next clock
    p_single_op_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.opc != OPC_FLUSH_ALL) |=> !st_q.busy);

    // R6: the walker keeps busy high until the last slot
    p_walk_keeps_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.opc == OPC_FLUSH_ALL && st_q.walk != SLOT_W'(TOTAL - 1)) |=> st_q.busy);

    // R7: get-next moves the index upward or reports none
    p_next_upward_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.opc == OPC_NEXT) |=>
        ((&st_q.idx) || (st_q.idx[IDX_W-1:0] > $past(st_q.idx[IDX_W-1:0]))));

    // R8: the block selection cannot move under a running operation
    p_block_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.ext));

endmodule

// File: rtl/tcam_page_engine.sv
module tcam_page_engine
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int BLOCKS  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [4:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
    localparam int SLOT_W = BLK_W + IDX_W;
    localparam int SLOTS  = 2 ** SLOT_W;

    logic [BLK_W-1:0]   blk_sel;
    logic [IDX_W-1:0]   search_start;
    logic               search_found;
    logic [IDX_W-1:0]   search_hit;
    logic [SLOT_W-1:0]  rd_entry;
    logic [1:0]         rd_page;
    page_t              rd_data;
    logic               wr_en;
    logic [SLOT_W-1:0]  wr_entry;
    logic [1:0]         wr_page;
    page_t              wr_data;
    logic               clr_en;
    logic [SLOT_W-1:0]  clr_entry;
    logic [SLOTS-1:0]   valid_all;
    logic [ENTRIES-1:0] blk_valid [BLOCKS];
    logic [ENTRIES-1:0] sel_valid;

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        assign blk_valid[b] = valid_all[b*ENTRIES +: ENTRIES];
    end

    assign sel_valid = blk_valid[blk_sel];

    tcam_op_ctrl #(.ENTRIES(ENTRIES), .BLOCKS(BLOCKS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .blk_sel      (blk_sel),
        .search_start (search_start),
        .search_found (search_found),
        .search_hit   (search_hit),
        .rd_entry     (rd_entry),
        .rd_page      (rd_page),
        .rd_data      (rd_data),
        .wr_en        (wr_en),
        .wr_entry     (wr_entry),
        .wr_page      (wr_page),
        .wr_data      (wr_data),
        .clr_en       (clr_en),
        .clr_entry    (clr_entry)
    );

    tcam_entry_store #(.SLOTS(SLOTS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_entry  (rd_entry),
        .rd_page   (rd_page),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .wr_page   (wr_page),
        .wr_data   (wr_data),
        .clr_en    (clr_en),
        .clr_entry (clr_entry),
        .valid     (valid_all)
    );

    tcam_next_finder #(.ENTRIES(ENTRIES)) u_find (
        .valid_blk (sel_valid),
        .start     (search_start),
        .found     (search_found),
        .hit       (search_hit)
    );

endmodule

// File: tb/sim_tcam_page_engine.sv
module sim_tcam_page_engine;

    localparam int ENTRIES = 16;
    localparam int BLOCKS  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tcam_page_engine #(.ENTRIES(ENTRIES), .BLOCKS(BLOCKS)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    function automatic logic [15:0] pat(int seed, int k);
        logic [15:0] v;
        v = 16'((seed * 4919 + k * 257 + 13) & 16'hFFFF);
        if (k == 0) v = v | 16'hC000;
        return v;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = a;
        host_wdata = v;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic issue(input int opc, input int page, input int idx, output int cyc);
        logic [15:0] v;
        wr(5'd0, 16'h8000 | 16'(opc << 12) | 16'(page << 10) | 16'(idx));
        cyc = 0;
        rd(5'd0, v);
        while (v[15] && cyc < 1000) begin
            cyc++;
            @(negedge clk);
            rd(5'd0, v);
        end
    endtask

    task automatic fill(input int seed);
        for (int k = 0; k < 26; k++) wr(5'(k + 2), pat(seed, k));
    endtask

    task automatic expect_regs(string tag, string what, input int seed, input bit zero);
        logic [15:0] v;
        int mism;
        mism = 0;
        for (int k = 0; k < 26; k++) begin
            rd(5'(k + 2), v);
            if (v != (zero ? 16'h0 : pat(seed, k))) mism++;
        end
        check(tag, what, mism, 0);
    endtask

    task automatic next_from(string tag, input int idx, input int exp_idx);
        logic [15:0] v;
        int cyc;
        issue(4, 0, idx, cyc);
        rd(5'd0, v);
        check(tag, $sformatf("get-next from %0d", idx), v, 16'h4000 | 16'(exp_idx));
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(5'd0, v);
        check("R1", "op reg after reset", v, 0);
        rd(5'd1, v);
        check("R1", "ext reg after reset", v, 0);
        expect_regs("R1", "data regs after reset", 0, 1'b1);
        next_from("R1", 0, 10'h3FF);
    endtask

    task automatic t_load_read();
        int cyc;
        logic [15:0] v;
        fill(1);
        issue(3, 1, 5, cyc);
        check("R2", "load busy cycles", cyc, 1);
        rd(5'd0, v);
        check("R2", "op reg after load", v, 16'h3405);
        fill(2);
        issue(3, 2, 5, cyc);
        fill(3);
        issue(5, 1, 5, cyc);
        check("R2", "read busy cycles", cyc, 1);
        expect_regs("R3", "read back page 1", 1, 1'b0);
        issue(5, 2, 5, cyc);
        expect_regs("R3", "read back page 2", 2, 1'b0);
    endtask

    task automatic t_page3();
        int cyc;
        fill(10);
        issue(3, 3, 5, cyc);
        fill(11);
        issue(5, 1, 5, cyc);
        expect_regs("R3", "page 1 after page-3 load", 1, 1'b0);
        issue(5, 3, 5, cyc);
        expect_regs("R3", "regs after page-3 read", 1, 1'b0);
    endtask

    task automatic t_no_busy();
        logic [15:0] v;
        fill(12);
        wr(5'd0, 16'h5405);
        repeat (3) @(negedge clk);
        rd(5'd0, v);
        check("R2", "op fields stored without busy", v, 16'h5405);
        expect_regs("R2", "no read without busy bit", 12, 1'b0);
    endtask

    task automatic t_valid_next();
        int cyc;
        fill(4);
        issue(3, 0, 3, cyc);
        fill(5);
        issue(3, 0, 9, cyc);
        fill(6);
        wr(5'd2, 16'h0000);
        issue(3, 0, 7, cyc);
        next_from("R4", 0, 3);
        next_from("R4", 3, 9);
        next_from("R7", 7, 9);
        next_from("R7", 9, 10'h3FF);
        next_from("R7", 15, 10'h3FF);
    endtask

    task automatic t_flush_one();
        int cyc;
        issue(2, 0, 3, cyc);
        check("R5", "flush-one busy cycles", cyc, 1);
        next_from("R5", 0, 9);
        issue(5, 0, 3, cyc);
        expect_regs("R5", "flushed page 0", 0, 1'b1);
        issue(5, 1, 5, cyc);
        expect_regs("R5", "other entry untouched", 1, 1'b0);
    endtask

    task automatic t_blocks();
        int cyc;
        logic [15:0] v;
        wr(5'd1, 16'h0001);
        rd(5'd1, v);
        check("R8", "ext readback", v, 1);
        fill(7);
        issue(3, 0, 3, cyc);
        next_from("R8", 0, 3);
        wr(5'd1, 16'h0000);
        next_from("R8", 0, 9);
        issue(5, 0, 3, cyc);
        expect_regs("R8", "block 0 slot 3 still clear", 0, 1'b1);
        wr(5'd1, 16'h0001);
        issue(5, 0, 3, cyc);
        expect_regs("R8", "block 1 slot 3 content", 7, 1'b0);
        wr(5'd1, 16'h0000);
    endtask

    task automatic t_flush_all();
        int cyc;
        issue(1, 0, 0, cyc);
        check("R6", "flush-all busy cycles", cyc, BLOCKS * ENTRIES);
        next_from("R6", 0, 10'h3FF);
        wr(5'd1, 16'h0001);
        next_from("R6", 0, 10'h3FF);
        wr(5'd1, 16'h0000);
        issue(5, 1, 5, cyc);
        expect_regs("R6", "page 1 cleared", 0, 1'b1);
    endtask

    task automatic t_busy_ignore();
        int cyc;
        logic [15:0] v;
        fill(8);
        wr(5'd0, 16'h9000);
        wr(5'd0, 16'hD405);
        wr(5'd2, 16'h1234);
        wr(5'd1, 16'h0001);
        cyc = 0;
        rd(5'd0, v);
        while (v[15] && cyc < 1000) begin
            cyc++;
            @(negedge clk);
            rd(5'd0, v);
        end
        check("R9", "op reg after busy writes", v, 16'h1000);
        rd(5'd1, v);
        check("R9", "ext reg after busy write", v, 0);
        expect_regs("R9", "data regs after busy write", 8, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_read();
        t_page3();
        t_no_busy();
        t_valid_next();
        t_flush_one();
        t_blocks();
        t_flush_all();
        t_busy_ignore();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule